// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a byte-addressed serial memory with an 8K-byte (13-bit) space. It oversamples the clock and data lines of a two-wire bus with a fast internal clock. It finds start and stop conditions and moves bytes in and out one bit per bus clock. It pulls the data line low only through an open-drain enable output.

A transfer opens with a control byte. When that byte carries the fixed device code and the strap-pin select value, the block accepts a two-byte word address and then a stream of write bytes. Each write byte leaves the block as a one-cycle strobe carrying the address and the data to an external write cache. A stop condition then requests a commit. A read control byte starts a read at the internal pointer, either directly or after an address phase and a repeated start. Read data comes from an external array over a synchronous read port, one cycle of latency. While the cache reports that a write is in progress, the block acknowledges nothing, so a master can poll for completion.

Top module: `twi_mem_front`

## Requirements
- R1: A falling data line while the clock is high is a start. A rising data line while the clock is high is a stop. A start at any point drops the byte in progress and restarts control-byte reception. A stop returns the block to idle.
- R2: A control byte is bits 7..4 = 1010, bits 3..1 = strap select, bit 0 = direction (1 = read). Only a matching control byte is acknowledged, by holding the data line low over the whole high phase of the ninth clock. A mismatching control byte and any later bytes before the next start or stop get no acknowledge and cause no strobe.
- R3: While busy_in is high, a control byte gets no acknowledge. Once busy_in is low, the same control byte is acknowledged.
- R4: After a write control byte, the high address byte comes first and then the low byte, each MSB first. Only bits 4..0 of the high byte are used, and its bits 7..5 are ignored.
- R5: Each write data byte is acknowledged. It raises wr_stb for one cycle with wr_addr equal to the pointer and wr_data equal to the byte. The pointer then advances by one.
- R6: A stop after at least one write data byte raises wr_commit for exactly one cycle. A transfer with no write data byte causes no commit.
- R7: A repeated start after the address bytes keeps the loaded pointer. A following read returns the byte at that address.
- R8: A read with no address phase starts at the pointer, which is the last accessed address plus one.
- R9: While the master acknowledges, successive bytes come from successive addresses. After a master no-acknowledge the data line is released and stays released until the next start or stop.
- R10: The pointer wraps from 0x1FFF to 0x0000 on both writes and reads.
- R11: The data-line enable changes only while the bus clock is low.
- R12: After reset the enable and all strobes are low and the pointer is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| dev_sel | input | SEL_W | Strap select value matched against control bits 3..1 |
| busy_in | input | 1 | Write cycle in progress in the cache |
| wr_stb | output | 1 | One-cycle write byte strobe |
| wr_addr | output | ADDR_W | Address of the strobed byte |
| wr_data | output | 8 | Strobed byte |
| wr_commit | output | 1 | One-cycle request to start the internal write |
| rd_en | output | 1 | Read request to the array |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | 8 | Array data, valid the cycle after rd_en |

## Verification
The assertions assume a well-behaved master. Its clock low phase is longer than the filter and output-delay latency. It changes data only in the middle of the low phase, except for start and stop. busy_in rises only after a commit, so no access can already be under way when it rises. The bench master holds each phase for 24 internal clocks and changes data half way through the low phase. It raises busy_in only in response to wr_commit, so all of these assumptions hold across the random write/read mix and the directed cases.

// File: rtl/twi_pkg.sv
package twi_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_CTRL, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT, ST_WAIT
   } twi_st_e;

   localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
   parameter bit FILT_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], din};
   end

   generate
      if (FILT_EN) begin : g_maj
         logic [2:0] hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_q <= 3'b111;
               dout   <= 1'b1;
            end else begin
               hist_q <= {hist_q[1:0], sync_q[1]};
               dout   <= (hist_q[0] & hist_q[1]) | (hist_q[1] & hist_q[2]) |
                         (hist_q[0] & hist_q[2]);
            end
         end
      end else begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout <= 1'b1;
            else        dout <= sync_q[1];
         end
      end
   endgenerate
endmodule

// File: rtl/twi_sda_delay.sv
module twi_sda_delay #(
   parameter int DLY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic oe
);
   logic [DLY-1:0] pipe_q;

   generate
      if (DLY == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= req;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= {pipe_q[DLY-2:0], req};
         end
      end
   endgenerate

   assign oe = pipe_q[DLY-1];
endmodule

// File: rtl/twi_mem_front.sv
module twi_mem_front
   import twi_pkg::*;
#(
   parameter int ADDR_W  = 13,
   parameter int SEL_W   = 3,
   parameter int SDA_DLY = 3,
   parameter bit FILT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   input  logic [SEL_W-1:0]  dev_sel,
   input  logic              busy_in,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              wr_commit,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data
);
   localparam int HI_W = ADDR_W - 8;

   generate
      if (SEL_W != 3) begin : g_bad_sel
         $error("twi_mem_front: control byte needs SEL_W == 3");
      end
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("twi_mem_front: ADDR_W must lie in 9..16");
      end
      if (SDA_DLY < 1 || SDA_DLY > 8) begin : g_bad_dly
         $error("twi_mem_front: SDA_DLY must lie in 1..8");
      end
   endgenerate

   logic scl_f, sda_f, scl_q, sda_q;

   twi_line_filter #(.FILT_EN(FILT_EN)) i_scl_filt (
      .clk(clk), .rst_n(rst_n), .din(scl_in), .dout(scl_f));
   twi_line_filter #(.FILT_EN(FILT_EN)) i_sda_filt (
      .clk(clk), .rst_n(rst_n), .din(sda_in), .dout(sda_f));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   logic start_ev, stop_ev, scl_rise, scl_fall;
   assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
   assign scl_rise = scl_f & ~scl_q;
   assign scl_fall = ~scl_f & scl_q;

   twi_st_e           state;
   logic [3:0]        bitcnt;
   logic              ack_ph, rw, drive, rd_pend, wr_seen;
   logic [7:0]        shreg, txreg;
   logic [ADDR_W-1:0] ptr;
   logic              rx_st, ctrl_hit;

   assign rx_st    = (state == ST_CTRL) || (state == ST_AHI) ||
                     (state == ST_ALO)  || (state == ST_WDAT);
   assign ctrl_hit = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == dev_sel) && !busy_in;

   twi_sda_delay #(.DLY(SDA_DLY)) i_sda_dly (
      .clk(clk), .rst_n(rst_n), .req(drive), .oe(sda_oe));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bitcnt    <= '0;
         ack_ph    <= 1'b0;
         rw        <= 1'b0;
         drive     <= 1'b0;
         rd_pend   <= 1'b0;
         wr_seen   <= 1'b0;
         shreg     <= '0;
         txreg     <= '1;
         ptr       <= '0;
         wr_stb    <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         wr_commit <= 1'b0;
         rd_en     <= 1'b0;
         rd_addr   <= '0;
      end else begin
         wr_stb    <= 1'b0;
         wr_commit <= 1'b0;
         rd_en     <= 1'b0;
         rd_pend   <= rd_en;
         if (rd_pend) txreg <= rd_data;

         if (start_ev) begin
            state   <= ST_CTRL;
            bitcnt  <= '0;
            ack_ph  <= 1'b0;
            drive   <= 1'b0;
            wr_seen <= 1'b0;
         end else if (stop_ev) begin
            state     <= ST_IDLE;
            ack_ph    <= 1'b0;
            drive     <= 1'b0;
            wr_commit <= wr_seen;
            wr_seen   <= 1'b0;
         end else if (scl_rise) begin
            if (rx_st && !ack_ph) begin
               shreg  <= {shreg[6:0], sda_f};
               bitcnt <= bitcnt + 4'd1;
            end else if (state == ST_RDAT) begin
               if (!ack_ph) begin
                  bitcnt <= bitcnt + 4'd1;
               end else if (!sda_f) begin
                  rd_en   <= 1'b1;
                  rd_addr <= ptr;
                  ptr     <= ptr + 1'b1;
               end else begin
                  state <= ST_WAIT;
               end
            end
         end else if (scl_fall) begin
            if (rx_st) begin
               if (ack_ph) begin
                  ack_ph <= 1'b0;
                  drive  <= 1'b0;
                  bitcnt <= '0;
                  case (state)
                     ST_CTRL: begin
                        if (rw) begin
                           state <= ST_RDAT;
                           drive <= ~txreg[7];
                        end else begin
                           state <= ST_AHI;
                        end
                     end
                     ST_AHI:  state <= ST_ALO;
                     ST_ALO:  state <= ST_WDAT;
                     default: state <= ST_WDAT;
                  endcase
               end else if (bitcnt == 4'd8) begin
                  bitcnt <= '0;
                  ack_ph <= 1'b1;
                  drive  <= 1'b1;
                  case (state)
                     ST_CTRL: begin
                        if (ctrl_hit) begin
                           rw <= shreg[0];
                           if (shreg[0]) begin
                              rd_en   <= 1'b1;
                              rd_addr <= ptr;
                              ptr     <= ptr + 1'b1;
                           end
                        end else begin
                           state  <= ST_WAIT;
                           ack_ph <= 1'b0;
                           drive  <= 1'b0;
                        end
                     end
                     ST_AHI: ptr[ADDR_W-1:8] <= shreg[HI_W-1:0];
                     ST_ALO: ptr[7:0]        <= shreg;
                     default: begin
                        wr_stb  <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= shreg;
                        ptr     <= ptr + 1'b1;
                        wr_seen <= 1'b1;
                     end
                  endcase
               end
            end else if (state == ST_RDAT) begin
               if (ack_ph) begin
                  ack_ph <= 1'b0;
                  bitcnt <= '0;
                  drive  <= ~txreg[7];
               end else if (bitcnt == 4'd8) begin
                  ack_ph <= 1'b1;
                  drive  <= 1'b0;
                  bitcnt <= '0;
               end else begin
                  txreg <= {txreg[6:0], 1'b0};
                  drive <= ~txreg[6];
               end
            end
         end
      end
   end
endmodule

// File: rtl/twi_mem_front_chk.sv
module twi_mem_front_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_in,
   input logic sda_oe,
   input logic busy_in,
   input logic wr_stb,
   input logic wr_commit,
   input logic rd_en
);
   AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_in); // R11

   AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |=> !wr_commit); // R6

   AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb); // R5

   AST_NO_ACCESS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_in && $past(busy_in)) |-> !(wr_stb || rd_en)); // R3

   AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_stb, rd_en, wr_commit})); // R5
endmodule

bind twi_mem_front twi_mem_front_chk i_twi_mem_front_chk (
   .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
   .busy_in(busy_in), .wr_stb(wr_stb), .wr_commit(wr_commit), .rd_en(rd_en));

// File: tb/test_twi_mem_front.sv
module test_twi_mem_front;
   localparam int H       = 24;
   localparam int BUSY_CY = 1200;
   localparam logic [2:0] SEL = 3'b101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic scl = 1'b1, sda_m = 1'b1, sda_oe, sda_line, busy_in;
   logic wr_stb, wr_commit, rd_en;
   logic [12:0] wr_addr, rd_addr;
   logic [7:0]  wr_data, rd_data;
   int checks = 0, errs = 0, stb_cnt = 0, commits = 0, busy_cnt = 0;
   logic [12:0] last_wa;
   logic [7:0]  last_wd;
   logic [12:0] exp_ptr;
   bit [7:0] cmem [int];
   bit [7:0] emem [int];

   assign sda_line = sda_m & ~sda_oe;
   assign busy_in  = (busy_cnt != 0);

   twi_mem_front i_twi_mem_front (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
      .dev_sel(SEL), .busy_in(busy_in), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_commit(wr_commit), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data));

   function automatic logic [7:0] pat(int a);
      return 8'(a * 7 + (a >> 8) + 8'h35);
   endfunction

   function automatic logic [7:0] exp_byte(int a);
      if (emem.exists(a)) return emem[a];
      return pat(a);
   endfunction

   // cache and array stand-in
   always @(posedge clk) begin
      if (wr_stb) begin
         cmem[int'(wr_addr)] = wr_data;
         stb_cnt++;
         last_wa = wr_addr;
         last_wd = wr_data;
      end
      if (wr_commit) begin
         commits++;
         busy_cnt = BUSY_CY;
      end else if (busy_cnt != 0) begin
         busy_cnt--;
      end
      if (rd_en) rd_data <= cmem.exists(int'(rd_addr)) ? cmem[int'(rd_addr)] : pat(int'(rd_addr));
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bstart();
      sda_m = 1'b1; tick(H/2);
      scl = 1'b1;   tick(H);
      sda_m = 1'b0; tick(H);
      scl = 1'b0;   tick(H/2);
   endtask

   task automatic bstop();
      sda_m = 1'b0; tick(H/2);
      scl = 1'b1;   tick(H);
      sda_m = 1'b1; tick(H);
   endtask

   task automatic clk_bit(logic b);
      sda_m = b; tick(H/2);
      scl = 1'b1; tick(H);
      scl = 1'b0; tick(H/2);
   endtask

   task automatic send_byte(logic [7:0] b, output logic ack);
      logic a1, a2;
      for (int i = 7; i >= 0; i--) clk_bit(b[i]);
      sda_m = 1'b1; tick(H/2);
      scl = 1'b1; tick(2); a1 = sda_line;
      tick(H-4); a2 = sda_line;
      tick(2); scl = 1'b0; tick(H/2);
      ack = !a1 && !a2;
   endtask

   task automatic recv_byte(output logic [7:0] b, input logic mack);
      logic o1, o2;
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; tick(H/2);
         scl = 1'b1; tick(2); o1 = sda_oe;
         tick(H/2-2); b[i] = sda_line;
         tick(H/2-2); o2 = sda_oe;
         tick(2); scl = 1'b0; tick(H/2);
         if (i == 7) chk("R11 enable steady in high phase", o2, o1);
      end
      sda_m = mack ? 1'b0 : 1'b1; tick(H/2);
      scl = 1'b1; tick(H);
      scl = 1'b0; tick(H/2);
      sda_m = 1'b1;
   endtask

   task automatic wr_seq(logic [12:0] addr, int n);
      logic ack;
      int c0;
      logic [7:0] d;
      c0 = commits;
      bstart();
      send_byte({4'b1010, SEL, 1'b0}, ack); chk("R2 write control ack", ack, 1'b1);
      send_byte({3'($urandom), addr[12:8]}, ack); chk("R4 high address ack", ack, 1'b1);
      send_byte(addr[7:0], ack); chk("R4 low address ack", ack, 1'b1);
      for (int i = 0; i < n; i++) begin
         d = 8'($urandom);
         send_byte(d, ack);
         chk("R5 data ack", ack, 1'b1);
         chk("R5 strobe address", last_wa, addr);
         chk("R5 strobe data", last_wd, d);
         emem[int'(addr)] = d;
         addr = addr + 13'd1;
      end
      bstop();
      chk("R6 commit after data", commits, c0 + 1);
      exp_ptr = addr;
   endtask

   task automatic wait_ready();
      logic ack;
      int tries;
      tries = 0;
      do begin
         bstart();
         send_byte({4'b1010, SEL, 1'b0}, ack);
         bstop();
         if (tries == 0) chk("R3 no ack while busy", ack, 1'b0);
         tries++;
      end while (!ack && tries < 20);
      chk("R3 ack once write done", ack, 1'b1);
   endtask

   task automatic rd_random(logic [12:0] addr, int n);
      logic ack;
      logic [7:0] b;
      int c0;
      c0 = commits;
      bstart();
      send_byte({4'b1010, SEL, 1'b0}, ack);
      send_byte({3'b000, addr[12:8]}, ack);
      send_byte(addr[7:0], ack);
      bstart();
      send_byte({4'b1010, SEL, 1'b1}, ack); chk("R7 read control ack", ack, 1'b1);
      for (int i = 0; i < n; i++) begin
         recv_byte(b, i != n - 1);
         chk("R7 R9 R10 read data", b, exp_byte(int'(addr)));
         addr = addr + 13'd1;
      end
      bstop();
      chk("R6 no commit without data", commits, c0);
      exp_ptr = addr;
   endtask

   task automatic rd_cur(int n);
      logic ack;
      logic [7:0] b;
      bstart();
      send_byte({4'b1010, SEL, 1'b1}, ack); chk("R8 current read ack", ack, 1'b1);
      for (int i = 0; i < n; i++) begin
         recv_byte(b, i != n - 1);
         chk("R8 current read data", b, exp_byte(int'(exp_ptr)));
         exp_ptr = exp_ptr + 13'd1;
      end
      bstop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errs++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      logic ack;
      logic [7:0] b;
      int s0, c0;
      logic bad;
      void'($urandom(32'h5eed));
      tick(5);
      rst_n = 1'b1;
      tick(5);
      chk("R12 enable low after reset", sda_oe, 1'b0);
      chk("R12 no write strobe", wr_stb, 1'b0);
      chk("R12 no read strobe", rd_en, 1'b0);
      exp_ptr = 13'd0;
      rd_cur(1); // R12 pointer starts at zero

      // R2 strap mismatch: no ack, later bytes ignored
      s0 = stb_cnt; c0 = commits;
      bstart();
      send_byte({4'b1010, SEL ^ 3'b001, 1'b0}, ack); chk("R2 mismatch no ack", ack, 1'b0);
      send_byte(8'h00, ack); chk("R2 ignored byte no ack", ack, 1'b0);
      send_byte(8'h5A, ack); chk("R2 ignored byte no ack", ack, 1'b0);
      bstop();
      chk("R2 no strobe after mismatch", stb_cnt, s0);
      chk("R2 no commit after mismatch", commits, c0);
      send_byte({4'b0110, SEL, 1'b1}, ack); chk("R2 wrong code no ack", ack, 1'b0);

      // R1 start aborts a partial byte
      bstart();
      for (int i = 0; i < 4; i++) clk_bit(i[0]);
      bstart();
      send_byte({4'b1010, SEL, 1'b1}, ack); chk("R1 ack after abort", ack, 1'b1);
      recv_byte(b, 1'b0);
      chk("R1 data after abort", b, exp_byte(int'(exp_ptr)));
      exp_ptr = exp_ptr + 13'd1;
      // R9 released after master no-ack, while clocking continues
      bad = 1'b0;
      for (int i = 0; i < 9; i++) begin
         sda_m = 1'b1; tick(H/2);
         scl = 1'b1; tick(H/2);
         if (sda_oe) bad = 1'b1;
         tick(H/2); scl = 1'b0; tick(H/2);
      end
      chk("R9 released after no-ack", bad, 1'b0);
      bstop();

      // R10 wrap on write and read
      wr_seq(13'h1FFF, 2);
      chk("R10 write wraps to zero", last_wa, 13'h0000);
      wait_ready();
      rd_random(13'h1FFE, 4);
      rd_cur(2); // R8 after wrap

      // mixed random traffic
      for (int it = 0; it < 5; it++) begin
         logic [12:0] a;
         int n;
         a = 13'($urandom);
         n = 1 + int'($urandom % 3);
         wr_seq(a, n);
         wait_ready();
         rd_random(a, n + 1);
         rd_cur(2);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end
endmodule